// File: doc/BRIEF.md
# Byte-Wide Register Slave on a Two-Wire Serial Bus

This block lets a two-wire serial bus master (the common I2C protocol, standard and fast rates) read and write a bank of 8-bit control registers. It runs entirely on one fast system clock. The bus lines SCL and SDA are synchronized, cleaned by a short glitch filter and then edge-detected, so the block has no clock of its own taken from the bus. SDA is an open-drain line. The block only ever asks for it to be pulled low, through a single drive output.

A transfer first names the device with a 7-bit address. Two address pairs exist, and a strap input chooses between them. In a write, the first byte after the address loads an internal pointer. Every byte after that is written to the pointer location, and the pointer then moves on by one. A read sets the pointer the same way, then issues a repeated start with the read address, and the block streams bytes from the pointer, moving it on after each byte. A byte written while the pointer sits at the top location (FFh) is not stored in a register. It produces a one-cycle store pulse, which the surrounding logic uses to commit staged settings.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 1011000 when `addr_sel` is 0, or 1011001 when `addr_sel` is 1. Bit 0 of that byte selects the direction: 0 means write and 1 means read. The byte values are therefore B0h/B1h for strap 0 and B2h/B3h for strap 1.
- R2: If the address does not match, no acknowledge is given. The block then ignores the bus, driving nothing and strobing nothing, until the next start condition.
- R3: In a write, the first byte after the address loads the pointer. Each later byte raises `reg_wr` for exactly one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte, and the pointer then increments, wrapping from FFh to 00h.
- R4: A data byte received while the pointer is FFh raises `store_pulse` for one cycle and raises no `reg_wr`. The pointer then wraps to 00h.
- R5: After a repeated start with the read address, the block returns `reg_rdata` at the pointer, most significant bit first. The pointer increments after each byte, so consecutive bytes come from consecutive locations.
- R6: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next start.
- R7: For every accepted address, pointer or data byte, the block holds SDA low during the ninth SCL clock. It releases SDA on the falling edge that ends that clock.
- R8: The block changes its SDA drive only while SCL is low.
- R9: A start or stop condition seen inside a byte aborts the transfer. A partial byte never causes a register write or a store pulse.
- R10: Operation is correct at SCL periods of 40 and 100 system clocks. An SCL pulse shorter than `FILT_LEN` system clocks is ignored.
- R11: During and right after reset, the block drives nothing on SDA and raises neither `reg_wr` nor `store_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line as seen on the pad |
| sda_in | input | 1 | SDA line as seen on the pad |
| addr_sel | input | 1 | Strap that selects the device address pair |
| sda_drive_low | output | 1 | When 1, the pad pulls SDA low |
| reg_wr | output | 1 | One-cycle register write strobe |
| store_pulse | output | 1 | One-cycle store strobe for a write to FFh |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Data for the register write |
| reg_rdata | input | 8 | Register content at `reg_addr` |

## Verification
The bench builds the block with its default address base and with `FILT_LEN` = 3. Three clocks is long enough that a one-cycle low spike injected on SCL during a data bit must be filtered out, and short enough that the filter delay stays well inside a quarter of the fast SCL period. Transfers are run with quarter periods of 10 and 25 system clocks, which stand for the two bus rates. These runs reach pointer wrap across FFh with the store pulse, both strap settings, a master NACK followed by extra clocks, and start and stop conditions cut into the middle of a byte.

// File: rtl/i2c_reg_slave.sv
`timescale 1ns/1ps
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1011000,
  parameter int         FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       addr_sel,
  output logic       sda_drive_low,
  output logic       reg_wr,
  output logic       store_pulse,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [FW-1:0] FMAX = FW'(FILT_LEN - 1);
  localparam logic [7:0] STORE_LOC = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_SUB, ST_SACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } st_t;

  logic [1:0] scl_s, sda_s;
  logic scl_f, sda_f, scl_q, sda_q;
  logic [FW-1:0] scl_c, sda_c;
  st_t st;
  logic [7:0] sh, ptr;
  logic [3:0] cnt;
  logic rw, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11;
      scl_f <= 1'b1;  sda_f <= 1'b1;
      scl_q <= 1'b1;  sda_q <= 1'b1;
      scl_c <= '0;    sda_c <= '0;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (scl_s[1] == scl_f) scl_c <= '0;
      else if (scl_c == FMAX) begin scl_f <= scl_s[1]; scl_c <= '0; end
      else scl_c <= scl_c + 1'b1;
      if (sda_s[1] == sda_f) sda_c <= '0;
      else if (sda_c == FMAX) begin sda_f <= sda_s[1]; sda_c <= '0; end
      else sda_c <= sda_c + 1'b1;
    end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire bus_start = scl_f & scl_q & sda_q & ~sda_f;
  wire bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
  wire [6:0] my_addr = {DEV_ADDR[6:1], addr_sel};

  assign reg_addr  = ptr;
  assign reg_wdata = sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; ptr <= '0; cnt <= '0;
      rw <= 1'b0; mack <= 1'b0;
      sda_drive_low <= 1'b0; reg_wr <= 1'b0; store_pulse <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      store_pulse <= 1'b0;
      if (bus_start) begin
        st <= ST_ADDR; cnt <= '0; sda_drive_low <= 1'b0;
      end else if (bus_stop) begin
        st <= ST_IDLE; sda_drive_low <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_SUB, ST_WDAT:
            if (scl_rise && cnt != 4'd8) begin
              sh <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == my_addr) begin
                  rw <= sh[0]; sda_drive_low <= 1'b1; st <= ST_AACK;
                end else st <= ST_IDLE;
              end else if (st == ST_SUB) begin
                ptr <= sh; sda_drive_low <= 1'b1; st <= ST_SACK;
              end else begin
                if (ptr == STORE_LOC) store_pulse <= 1'b1;
                else reg_wr <= 1'b1;
                sda_drive_low <= 1'b1; st <= ST_WACK;
              end
            end
          ST_AACK:
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh <= reg_rdata; sda_drive_low <= ~reg_rdata[7]; st <= ST_RDAT;
              end else begin
                sda_drive_low <= 1'b0; st <= ST_SUB;
              end
            end
          ST_SACK:
            if (scl_fall) begin sda_drive_low <= 1'b0; st <= ST_WDAT; end
          ST_WACK:
            if (scl_fall) begin
              sda_drive_low <= 1'b0; ptr <= ptr + 8'd1; st <= ST_WDAT;
            end
          ST_RDAT:
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_drive_low <= 1'b0; ptr <= ptr + 8'd1; st <= ST_RACK;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_drive_low <= ~sh[6];
              end
            end
          ST_RACK:
            if (scl_rise) mack <= ~sda_f;
            else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                sh <= reg_rdata; sda_drive_low <= ~reg_rdata[7]; st <= ST_RDAT;
              end else st <= ST_IDLE;
            end
          default: ;
        endcase
      end
    end

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_f); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!sda_drive_low && !reg_wr)); // R2
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R3
  AST_STORE_NOT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |-> (!reg_wr && reg_addr == STORE_LOC)); // R4
  AST_NO_WR_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr != STORE_LOC)); // R4
  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |=> !store_pulse); // R4
endmodule

// File: tb/i2c_reg_slave_tb.sv
`timescale 1ns/1ps
module i2c_reg_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
  logic sda_drive_low, reg_wr, store_pulse;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire sda_bus = m_sda & ~sda_drive_low;

  i2c_reg_slave #(.FILT_LEN(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .addr_sel(addr_sel),
    .sda_drive_low(sda_drive_low), .reg_wr(reg_wr), .store_pulse(store_pulse),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #2.5 clk = ~clk;

  logic [7:0] bank [256];
  logic [7:0] mdl  [256];
  logic [16:0] exp_q [$];
  int n_cmp = 0, n_bad = 0, q = 10;
  logic prev_drv = 1'b0;

  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) if (reg_wr) bank[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (sda_drive_low != prev_drv && m_scl)
      chk(0, "R8 drive changed with SCL high", {31'd0, sda_drive_low}, {31'd0, prev_drv});
    prev_drv = sda_drive_low;
    if (reg_wr || store_pulse) begin
      if (exp_q.size() == 0)
        chk(0, "R9/R2 unexpected strobe", {15'd0, store_pulse, reg_addr, reg_wdata}, 0);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        if (e[16])
          chk(store_pulse && !reg_wr && reg_addr == 8'hFF, "R4 store pulse",
              {15'd0, store_pulse, reg_addr, 8'd0}, {15'd0, 1'b1, 8'hFF, 8'd0});
        else
          chk(reg_wr && !store_pulse && reg_addr == e[15:8] && reg_wdata == e[7:0], "R3 register write",
              {15'd0, store_pulse, reg_addr, reg_wdata}, {15'd0, e});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start;
    m_sda = 1; tick(q); m_scl = 1; tick(q); m_sda = 0; tick(q); m_scl = 0; tick(q);
  endtask

  task automatic i2c_stop;
    m_sda = 0; tick(q); m_scl = 1; tick(q); m_sda = 1; tick(2 * q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb, input bit glitch);
    for (int i = 0; i < nb; i++) begin
      m_sda = b[7 - i]; tick(q); m_scl = 1; tick(q);
      if (glitch && i == 3) begin m_scl = 0; tick(1); m_scl = 1; end
      tick(q); m_scl = 0; tick(q);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit glitch, output bit ack);
    send_bits(b, 8, glitch);
    m_sda = 1; tick(q); m_scl = 1; tick(q); ack = ~sda_bus; tick(q); m_scl = 0; tick(q);
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] d);
    m_sda = 1;
    for (int i = 0; i < 8; i++) begin
      tick(q); m_scl = 1; tick(q); d[7 - i] = sda_bus; tick(q); m_scl = 0;
    end
    tick(q);
    m_sda = mack ? 1'b0 : 1'b1; tick(q); m_scl = 1; tick(2 * q); m_scl = 0; tick(q); m_sda = 1;
  endtask

  task automatic wr_txn(input logic [7:0] dev, input logic [7:0] sub, input logic [7:0] d[$],
                        input bit exp_ack, input bit glitch);
    bit a;
    i2c_start;
    wr_byte(dev, 0, a);
    chk(a == exp_ack, "R1 address acknowledge", {31'd0, a}, {31'd0, exp_ack});
    wr_byte(sub, 0, a);
    chk(a == exp_ack, exp_ack ? "R7 pointer ack" : "R2 ignored after mismatch", {31'd0, a}, {31'd0, exp_ack});
    for (int i = 0; i < d.size(); i++) begin
      logic [7:0] ad;
      ad = sub + 8'(i);
      if (exp_ack) begin
        if (ad == 8'hFF) exp_q.push_back({1'b1, 8'hFF, 8'h00});
        else begin exp_q.push_back({1'b0, ad, d[i]}); mdl[ad] = d[i]; end
      end
      wr_byte(d[i], glitch && i == 0, a);
      chk(a == exp_ack, exp_ack ? "R7 data ack" : "R2 data ignored", {31'd0, a}, {31'd0, exp_ack});
    end
    i2c_stop;
  endtask

  task automatic rd_txn(input logic [7:0] devw, input logic [7:0] sub, input int n);
    bit a;
    logic [7:0] d;
    i2c_start;
    wr_byte(devw, 0, a);
    chk(a, "R1 write address ack", {31'd0, a}, 1);
    wr_byte(sub, 0, a);
    chk(a, "R7 pointer ack", {31'd0, a}, 1);
    i2c_start;
    wr_byte(devw | 8'h01, 0, a);
    chk(a, "R1 read address ack", {31'd0, a}, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, d);
      chk(d == mdl[8'(sub + 8'(i))], "R5 read data", {24'd0, d}, {24'd0, mdl[8'(sub + 8'(i))]});
    end
    chk(!sda_drive_low, "R6 released after NACK", {31'd0, sda_drive_low}, 0);
    rd_byte(0, d);
    chk(d == 8'hFF, "R6 silent after NACK", {24'd0, d}, 8'hFF);
    i2c_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) begin
      bank[i] = 8'(i * 37 + 5);
      mdl[i]  = 8'(i * 37 + 5);
    end
    tick(5);
    chk(!sda_drive_low && !reg_wr && !store_pulse, "R11 reset quiet",
        {29'd0, sda_drive_low, reg_wr, store_pulse}, 0);
    rst_n = 1; tick(5);
    chk(!sda_drive_low && !reg_wr && !store_pulse, "R11 after reset",
        {29'd0, sda_drive_low, reg_wr, store_pulse}, 0);

    q = 10;
    wr_txn(8'hB0, 8'h10, '{8'h3C, 8'hA5, 8'h00}, 1, 0);
    rd_txn(8'hB0, 8'h10, 3);
    wr_txn(8'hFE, 8'h00, '{8'h11}, 0, 0);           // R2 foreign address
    wr_txn(8'hB0, 8'hFE, '{8'h11, 8'h22, 8'h33}, 1, 0); // R4 wrap through store
    rd_txn(8'hB0, 8'hFE, 3);

    q = 25;                                         // R10 slow rate
    wr_txn(8'hB0, 8'h80, '{8'h5A, 8'hC3}, 1, 1);    // R10 glitch on SCL
    rd_txn(8'hB0, 8'h7F, 4);

    addr_sel = 1;
    wr_txn(8'hB2, 8'h20, '{8'h77}, 1, 0);
    wr_txn(8'hB0, 8'h21, '{8'h99}, 0, 0);           // R1 old pair refused
    rd_txn(8'hB2, 8'h20, 2);

    q = 10;
    i2c_start; wr_byte(8'hB2, 0, a); wr_byte(8'h40, 0, a);
    send_bits(8'h00, 4, 0); i2c_stop;               // R9 stop mid-byte
    i2c_start; wr_byte(8'hB2, 0, a); wr_byte(8'h41, 0, a);
    send_bits(8'h00, 5, 0);
    i2c_start;                                      // R9 start mid-byte
    wr_byte(8'hB2, 0, a);
    chk(a, "R9 restart accepted", {31'd0, a}, 1);
    wr_byte(8'h42, 0, a);
    exp_q.push_back({1'b0, 8'h42, 8'hE1}); mdl[8'h42] = 8'hE1;
    wr_byte(8'hE1, 0, a);
    i2c_stop;
    rd_txn(8'hB2, 8'h40, 3);

    tick(20);
    chk(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule